// File: doc/BRIEF.md
# DRAM Command Sequencer

This block is a small programmable engine that plays raw DRAM command words out of a local table while it holds the memory bus. A host fills the table through a plain write port. Each table slot has two 64-bit words. The pin word holds the clock-enable, chip-select, command and address fields that are driven onto the DRAM pins. The control word holds a successor index, an idle count, a repeat count and a stop-here flag.

The host writes a target-port register, then pulses `start`. The engine begins at slot 0 and issues each slot for one cycle. After each issue it inserts the requested deselect cycles and repeats the slot as many times as told. It then jumps to the successor slot. When it meets a slot marked final, or a successor index beyond the table, it finishes and pulses `done`. While the engine runs, `ref_block` holds off the normal controller's refresh. A `stop` pulse aborts the run at any time and parks the pins in the deselect state.

Top module: `cmd_seq_engine`

## Requirements
- R1: A write (`wr_en`=1) stores `wr_data` into slot `wr_idx`: the pin word when `wr_ctl`=0, the control word when `wr_ctl`=1. Writes that arrive while `busy`=1 leave the table unchanged.
- R2: A `start` pulse while idle begins execution at slot 0. A `start` pulse while `busy`=1 has no effect on the run in progress.
- R3: Pin-word layout: bits [1:0] are CKE, bits [3:2] are the active-low chip selects of ranks 0-1, bits [5:4] are those of ranks 2-3, bits [9:6] are the command and bits [27:10] are the address. An issued slot appears on the pins for one cycle, one clock after the engine reaches it.
- R4: A slot with idle count I and repeat count N is issued N+1 times, and each issue is followed by I deselect cycles. I=0 and N=0 give a single issue with no added cycles.
- R5: Control-word layout: bits [5:0] are the successor index, [21:6] the idle count, [37:22] the repeat count and bit [38] the final flag. After a slot completes, execution continues at the successor. A successor index of 32 or more ends the run.
- R6: A slot flagged final is issued once, and its idle and repeat counts are not honoured. Every normal completion drives `busy` low and `done` high for exactly one cycle.
- R7: `busy` is high from the cycle after `start` until the completing edge. Its length is 1 plus the sum over the non-final slots of (N+1)x(1+I).
- R8: A `stop` pulse drives `busy` low on the next cycle and leaves all chip selects high. No `done` pulse follows, and no further command is issued.
- R9: Only the port held in the port-select register (`psel_data`, loaded by `psel_we`) sees chip selects low. All other ports stay deselected. Port-select writes while `busy`=1 are ignored.
- R10: Out of reset and whenever no slot is being issued, every chip select is high. CKE keeps the value of the last issued slot, and is 0 after reset.
- R11: `ref_block` is high exactly while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | $clog2(DEPTH) | Slot being written |
| wr_ctl | input | 1 | 0 selects the pin word, 1 selects the control word |
| wr_data | input | 64 | Word to store |
| psel_we | input | 1 | Port-select register write strobe |
| psel_data | input | $clog2(NPORT) | Target port number |
| start | input | 1 | Begin execution at slot 0 |
| stop | input | 1 | Abort execution |
| busy | output | 1 | Engine running |
| done | output | 1 | One-cycle pulse on normal completion |
| ref_block | output | 1 | Holds off the normal controller's refresh |
| dram_cke | output | 2 | Clock-enable pins |
| dram_cmd | output | 4 | Command pins |
| dram_addr | output | 18 | Address pins |
| dram_cs_n | output | NPORT*4 | Active-low chip selects, four per port |

## Verification
The hardest situation to reach from the ports is a table or port-select write, or a second `start`, that lands while the engine sits in the middle of a long idle wait. To reach it, the bench drives these host actions from inside its own per-cycle sampling loop, at a chosen busy cycle. It then checks the run length, which slots appeared and on which port, and re-runs the program to show the table and the port selection were untouched. A stop issued during a 100-cycle wait, followed by a long quiet window, covers the abort path.

// File: rtl/cmd_seq_pkg.sv
`timescale 1ns/1ps
package cmd_seq_pkg;
    localparam int WORD_W = 64;
    localparam int IDX_W  = 6;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 18;
    localparam int CKE_W  = 2;
    localparam int CS_W   = 4;
    localparam int CMD_W  = 4;

    // pin word, LSB first: cke, cs ranks 0-1, cs ranks 2-3, cmd, addr
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic [CS_W-1:0]   cs_n;
        logic [CKE_W-1:0]  cke;
    } pins_t;

    // control word, LSB first: successor, idle, repeat, final flag
    typedef struct packed {
        logic              last;
        logic [CNT_W-1:0]  rep;
        logic [CNT_W-1:0]  idle;
        logic [IDX_W-1:0]  nxt;
    } ctl_t;

    localparam int PIN_W = $bits(pins_t);
    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;
endpackage

// File: rtl/cmd_seq_array.sv
`timescale 1ns/1ps
module cmd_seq_array
    import cmd_seq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic              wr_ctl,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output pins_t             rd_pins,
    output ctl_t              rd_ctl
);
    pins_t pin_mem [DEPTH];
    ctl_t  ctl_mem [DEPTH];

    // table is frozen while a program runs
    always_ff @(posedge clk) begin
        if (wr_en && !busy) begin
            if (wr_ctl) ctl_mem[wr_idx] <= ctl_t'(wr_data[CTL_W-1:0]);
            else        pin_mem[wr_idx] <= pins_t'(wr_data[PIN_W-1:0]);
        end
    end

    assign rd_pins = pin_mem[rd_idx];
    assign rd_ctl  = ctl_mem[rd_idx];

    logic unused_hi;
    assign unused_hi = ^wr_data[WORD_W-1:CTL_W];
endmodule

// File: rtl/cmd_seq_ctrl.sv
`timescale 1ns/1ps
module cmd_seq_ctrl
    import cmd_seq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  ctl_t          cur,
    output logic [AW-1:0] pc,
    output logic          issue,
    output logic          busy,
    output logic          done
);
    seq_state_e       state;
    logic [CNT_W-1:0] rep_cnt;
    logic [CNT_W-1:0] wait_cnt;
    logic             slot_end, more_reps, next_bad;

    always_comb begin
        more_reps = rep_cnt < cur.rep;
        next_bad  = int'(cur.nxt) >= DEPTH;
        slot_end  = (state == S_ISSUE && !cur.last && cur.idle == '0) ||
                    (state == S_WAIT && wait_cnt == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            pc       <= '0;
            rep_cnt  <= '0;
            wait_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (stop) begin
                state <= S_IDLE;
            end else if (state == S_IDLE) begin
                if (start) begin
                    state   <= S_ISSUE;
                    pc      <= '0;
                    rep_cnt <= '0;
                end
            end else if (state == S_ISSUE && cur.last) begin
                state <= S_IDLE;
                done  <= 1'b1;
            end else if (slot_end) begin
                if (more_reps) begin
                    rep_cnt <= rep_cnt + 1'b1;
                    state   <= S_ISSUE;
                end else if (next_bad) begin
                    state <= S_IDLE;
                    done  <= 1'b1;
                end else begin
                    pc      <= cur.nxt[AW-1:0];
                    rep_cnt <= '0;
                    state   <= S_ISSUE;
                end
            end else if (state == S_ISSUE) begin
                state    <= S_WAIT;
                wait_cnt <= cur.idle;
            end else begin
                wait_cnt <= wait_cnt - 1'b1;
            end
        end
    end

    assign issue = (state == S_ISSUE) && !stop;
    assign busy  = (state != S_IDLE);

    // R8
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> !busy);
    // R6
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));
    // R4
    wait_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT) |-> (wait_cnt != '0));
    // R2
    no_spurious_run_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/cmd_seq_pins.sv
`timescale 1ns/1ps
module cmd_seq_pins
    import cmd_seq_pkg::*;
#(
    parameter int NPORT = 4,
    localparam int PW = $clog2(NPORT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  issue,
    input  logic                  busy,
    input  pins_t                 ent,
    input  logic                  psel_we,
    input  logic [PW-1:0]         psel_data,
    output logic [CKE_W-1:0]      dram_cke,
    output logic [CMD_W-1:0]      dram_cmd,
    output logic [ADDR_W-1:0]     dram_addr,
    output logic [NPORT*CS_W-1:0] dram_cs_n
);
    pins_t         drv_q;
    logic [PW-1:0] port_q;
    logic [NPORT-1:0] port_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q  <= '{addr: '0, cmd: '0, cs_n: '1, cke: '0};
            port_q <= '0;
        end else begin
            if (psel_we && !busy) port_q <= psel_data;
            if (issue) drv_q <= ent;
            else       drv_q.cs_n <= '1;
        end
    end

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port
            assign dram_cs_n[p*CS_W +: CS_W] = (port_q == PW'(p)) ? drv_q.cs_n : '1;
            assign port_low[p] = ~&dram_cs_n[p*CS_W +: CS_W];
        end
    endgenerate

    assign dram_cke  = drv_q.cke;
    assign dram_cmd  = drv_q.cmd;
    assign dram_addr = drv_q.addr;

    // R9
    one_port_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_low));
    // R10
    idle_desel_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> (&dram_cs_n));
    // R10
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(dram_cke));
endmodule

// File: rtl/cmd_seq_engine.sv
`timescale 1ns/1ps
module cmd_seq_engine
    import cmd_seq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NPORT = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx,
    input  logic                       wr_ctl,
    input  logic [63:0]                wr_data,
    input  logic                       psel_we,
    input  logic [$clog2(NPORT)-1:0]   psel_data,
    input  logic                       start,
    input  logic                       stop,
    output logic                       busy,
    output logic                       done,
    output logic                       ref_block,
    output logic [1:0]                 dram_cke,
    output logic [3:0]                 dram_cmd,
    output logic [17:0]                dram_addr,
    output logic [NPORT*4-1:0]         dram_cs_n
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] pc;
    logic          issue;
    pins_t         cur_pins;
    ctl_t          cur_ctl;

    cmd_seq_array #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ctl(wr_ctl), .wr_data(wr_data), .rd_idx(pc),
        .rd_pins(cur_pins), .rd_ctl(cur_ctl)
    );

    cmd_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .cur(cur_ctl),
        .pc(pc), .issue(issue), .busy(busy), .done(done)
    );

    cmd_seq_pins #(.NPORT(NPORT)) u_pins (
        .clk(clk), .rst(rst), .issue(issue), .busy(busy), .ent(cur_pins),
        .psel_we(psel_we), .psel_data(psel_data), .dram_cke(dram_cke),
        .dram_cmd(dram_cmd), .dram_addr(dram_addr), .dram_cs_n(dram_cs_n)
    );

    assign ref_block = busy;
endmodule

// File: tb/cmd_seq_engine_tb_top.sv
`timescale 1ns/1ps
module cmd_seq_engine_tb_top;
    localparam logic [3:0] CMD_A = 4'h3;
    localparam logic [3:0] CMD_B = 4'h5;
    localparam logic [3:0] CMD_C = 4'h9;
    localparam logic [3:0] CMD_D = 4'hF;
    localparam int NROW = 5;
    // idle0, rep0, idle1, rep1, busy cycles, A issues, B issues, port
    localparam int TBL [NROW][8] = '{
        '{0, 0, 0, 0,  3, 1, 1, 0},
        '{2, 0, 0, 0,  5, 1, 1, 1},
        '{0, 2, 0, 0,  5, 3, 1, 2},
        '{1, 1, 3, 0,  9, 2, 1, 3},
        '{2, 2, 1, 1, 14, 3, 2, 0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_ctl = 1'b0, psel_we = 1'b0, start = 1'b0, stop = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  psel_data = '0;
    logic        busy, done, ref_block;
    logic [1:0]  dram_cke;
    logic [3:0]  dram_cmd;
    logic [17:0] dram_addr;
    logic [15:0] dram_cs_n;

    int checks = 0, errors = 0;
    int cur_port = 0;
    int bcy, na, nb, nc, nd, xlow, rbad;

    always #10 clk = ~clk;

    cmd_seq_engine dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_ctl(wr_ctl),
        .wr_data(wr_data), .psel_we(psel_we), .psel_data(psel_data),
        .start(start), .stop(stop), .busy(busy), .done(done), .ref_block(ref_block),
        .dram_cke(dram_cke), .dram_cmd(dram_cmd), .dram_addr(dram_addr),
        .dram_cs_n(dram_cs_n)
    );

    function automatic logic [63:0] pw(logic [1:0] cke, logic [1:0] cs01, logic [1:0] cs23,
                                       logic [3:0] cmd, logic [17:0] addr);
        return {36'b0, addr, cmd, cs23, cs01, cke};
    endfunction

    function automatic logic [63:0] cw(int nxt, int idle, int rep, bit last);
        return {25'b0, last, 16'(rep), 16'(idle), 6'(nxt)};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, bit ctl, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_ctl = ctl; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_port(int p);
        @(negedge clk);
        psel_we = 1'b1; psel_data = 2'(p);
        @(negedge clk);
        psel_we = 1'b0;
        cur_port = p;
    endtask

    // poke: busy cycle at which start, a slot-1 write and a port write are driven (0 = none)
    task automatic run_prog(int poke);
        logic [3:0] sel;
        bcy = 0; na = 0; nb = 0; nc = 0; nd = 0; xlow = 0; rbad = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        forever begin
            sel = dram_cs_n[cur_port*4 +: 4];
            if (sel != 4'hF) begin
                if (dram_cmd == CMD_A) na++;
                else if (dram_cmd == CMD_B) nb++;
                else if (dram_cmd == CMD_C) nc++;
            end
            for (int p = 0; p < 4; p++)
                if (p != cur_port && dram_cs_n[p*4 +: 4] != 4'hF) xlow++;
            if (done) nd++;
            if (ref_block != busy) rbad++;
            if (!busy || bcy > 4000) break;
            bcy++;
            if (bcy == poke) begin
                start = 1'b1;
                wr_en = 1'b1; wr_idx = 5'd1; wr_ctl = 1'b0;
                wr_data = pw(2'b11, 2'b00, 2'b00, CMD_C, 18'h0);
                psel_we = 1'b1; psel_data = 2'd3;
            end
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0; psel_we = 1'b0;
        end
        @(negedge clk);
        if (done) nd++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset cs_n", int'(dram_cs_n), 16'hFFFF);
        chk("R10 reset cke", int'(dram_cke), 0);
        chk("R7 reset busy", int'(busy), 0);
        chk("R11 reset ref_block", int'(ref_block), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 idle done", int'(done), 0);

        // table-driven programs: A, B, then a final DES slot with counts to be ignored
        for (int i = 0; i < NROW; i++) begin
            wr(0, 0, pw(2'b11, 2'b00, 2'b00, CMD_A, 18'(i)));
            wr(0, 1, cw(1, TBL[i][0], TBL[i][1], 0));
            wr(1, 0, pw(2'b11, 2'b00, 2'b00, CMD_B, 18'(i)));
            wr(1, 1, cw(2, TBL[i][2], TBL[i][3], 0));
            wr(2, 0, pw(2'b11, 2'b11, 2'b11, CMD_D, 18'h0));
            wr(2, 1, cw(3, 5, 3, 1));
            set_port(TBL[i][7]);
            run_prog(0);
            chk($sformatf("R7 R6 busy length row %0d", i), bcy, TBL[i][4]);
            chk($sformatf("R4 issues of A row %0d", i), na, TBL[i][5]);
            chk($sformatf("R4 issues of B row %0d", i), nb, TBL[i][6]);
            chk($sformatf("R6 done pulses row %0d", i), nd, 1);
            chk($sformatf("R9 other ports row %0d", i), xlow, 0);
            chk($sformatf("R11 ref_block row %0d", i), rbad, 0);
        end

        // R5: successor beyond the table ends the run
        wr(0, 0, pw(2'b11, 2'b00, 2'b00, CMD_A, 18'h0));
        wr(0, 1, cw(40, 0, 0, 0));
        wr(1, 0, pw(2'b11, 2'b00, 2'b00, CMD_B, 18'h0));
        wr(1, 1, cw(2, 0, 0, 1));
        set_port(0);
        run_prog(0);
        chk("R5 out-of-range busy", bcy, 1);
        chk("R5 out-of-range A", na, 1);
        chk("R5 out-of-range B", nb, 0);
        chk("R5 out-of-range done", nd, 1);

        // R5: non-sequential successor skips slot 1
        wr(0, 1, cw(7, 0, 0, 0));
        wr(7, 0, pw(2'b11, 2'b00, 2'b00, CMD_B, 18'h0));
        wr(7, 1, cw(2, 0, 0, 0));
        wr(1, 0, pw(2'b11, 2'b00, 2'b00, CMD_C, 18'h0));
        wr(1, 1, cw(2, 0, 0, 0));
        run_prog(0);
        chk("R5 jump busy", bcy, 3);
        chk("R5 jump A", na, 1);
        chk("R5 jump B", nb, 1);
        chk("R5 jump skipped C", nc, 0);

        // R3 / R10: chip-select pairs, address, CKE hold
        wr(0, 0, pw(2'b01, 2'b00, 2'b11, CMD_A, 18'h2A5A5));
        wr(0, 1, cw(1, 0, 0, 0));
        wr(1, 0, pw(2'b10, 2'b11, 2'b11, CMD_D, 18'h0));
        wr(1, 1, cw(0, 0, 0, 1));
        set_port(2);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk("R3 cs_n on port 2", int'(dram_cs_n[11:8]), 4'b1100);
        chk("R3 cmd", int'(dram_cmd), int'(CMD_A));
        chk("R3 addr", int'(dram_addr), 18'h2A5A5);
        chk("R3 cke", int'(dram_cke), 2'b01);
        repeat (4) @(negedge clk);
        chk("R10 cke held after run", int'(dram_cke), 2'b10);
        chk("R10 cs_n high after run", int'(dram_cs_n), 16'hFFFF);

        // R8: stop during a long wait
        wr(0, 0, pw(2'b11, 2'b00, 2'b00, CMD_A, 18'h0));
        wr(0, 1, cw(1, 100, 0, 0));
        wr(1, 0, pw(2'b11, 2'b00, 2'b00, CMD_B, 18'h0));
        wr(1, 1, cw(2, 0, 0, 1));
        set_port(0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 busy before stop", int'(busy), 1);
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk("R8 busy after stop", int'(busy), 0);
        chk("R8 cs_n after stop", int'(dram_cs_n), 16'hFFFF);
        nb = 0; nd = 0;
        for (int c = 0; c < 150; c++) begin
            if (done) nd++;
            if (dram_cs_n != 16'hFFFF) nb++;
            @(negedge clk);
        end
        chk("R8 no done after stop", nd, 0);
        chk("R8 no command after stop", nb, 0);

        // R2 / R1 / R9: start, slot write and port write while busy
        wr(0, 1, cw(1, 10, 0, 0));
        set_port(1);
        run_prog(4);
        chk("R2 restart ignored busy", bcy, 12);
        chk("R2 restart ignored A", na, 1);
        chk("R1 busy write ignored B", nb, 1);
        chk("R1 busy write ignored C", nc, 0);
        run_prog(0);
        chk("R1 table kept B", nb, 1);
        chk("R1 table kept C", nc, 0);
        chk("R9 port kept A", na, 1);
        chk("R9 port kept others", xlow, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule